// File: doc/BRIEF.md
# Audio Serial Port Control and Interrupt Register Block

This block is the software-facing register file of a multi-channel audio serial port. A host reaches it over a simple 32-bit read/write bus with byte offsets on word boundaries. A write-only command word turns the receiver, the transmitter and the bit clock on and off, and can also clear the block's run-time state. A status word shows which directions are running. Two free-form mode words are stored for the datapath, and a fixed revision word can be read.

Per-channel and FIFO events arrive from the datapath. Ready conditions arrive as levels. Error events (underrun, overflow, write error, receive FIFO full) arrive as one-cycle pulses and are held until software reads them. Each of the two interrupt groups has a set-enable address, a clear-enable address, a readable mask and a status word. A single interrupt line is high whenever any enabled status bit is set.

Top module: `audio_port_regs`

## Requirements
- R1: Command offset 0x00 controls three run states when written: bit 0 turns the receiver on and bit 1 turns it off; bit 2 turns the bit clock on and bit 3 turns it off; bit 4 turns the transmitter on and bit 5 turns it off. From the cycle after the write, status offset 0x0C shows the receiver state in bit 0 and the transmitter state in bit 4, with all other bits zero. The outputs `rx_on`, `clk_on` and `tx_on` show the three states.
- R2: When one command write sets both the on bit and the off bit of the same state, that state ends up off.
- R3: Command bit 7 clears all three run states, both interrupt masks and all latched status flags on the next edge. The other bits of that write are ignored. The two mode words keep their contents.
- R4: The command offset always reads as zero. Mode words at 0x04 and 0x08 are 32-bit read/write and reset to zero.
- R5: A write to 0x10 (group A) or 0x20 (group B) sets each mask bit where the written word has a one. A write to 0x14 or 0x24 clears each such bit. Zero bits leave the mask unchanged. The masks read back at 0x18 and 0x28. Group B implements mask bits 0, 8, 9, 12 and 13 only, and the other bits read as zero.
- R6: Group A status at 0x1C holds the channel n flags at bit n + base. The bases are: transmit ready 0 (live level), transmit underrun 8 (latched), receive ready 16 (live level) and receive overflow 24 (latched).
- R7: Group B status at 0x2C holds these flags: write error at bit 0 (latched), transmit FIFO ready at bit 8 (live), transmit FIFO empty at bit 9 (live), receive FIFO ready at bit 12 (live) and receive FIFO full at bit 13 (latched).
- R8: A latched flag is set by its input pulse and stays set until its group's status word is read. That read returns the flag and clears it. A pulse in the same cycle as the read leaves the flag set.
- R9: `irq` is high exactly when some bit is set in both a mask and its status word, in either group.
- R10: Offset 0xFC returns the revision parameter in bits 11:0 and zeros above it. Unmapped offsets read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe; reading a status word clears its latched flags |
| bus_addr | input | 8 | Byte offset |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of bus_rd |
| tx_rdy_i | input | NCH | Per-channel transmit ready levels |
| tx_unf_i | input | NCH | Per-channel transmit underrun pulses |
| rx_rdy_i | input | NCH | Per-channel receive ready levels |
| rx_ovf_i | input | NCH | Per-channel receive overflow pulses |
| wr_err_i | input | 1 | Write error pulse |
| txf_rdy_i | input | 1 | Transmit FIFO ready level |
| txf_emp_i | input | 1 | Transmit FIFO empty level |
| rxf_rdy_i | input | 1 | Receive FIFO ready level |
| rxf_ful_i | input | 1 | Receive FIFO full pulse |
| rx_on | output | 1 | Receiver running |
| clk_on | output | 1 | Bit clock running |
| tx_on | output | 1 | Transmitter running |
| irq | output | 1 | Interrupt request |

## Verification
The command word is swept over all 64 on/off patterns from each of the eight starting run states. This separates the hold, set and clear actions from one another and shows where disable takes priority. The masks are swept one bit at a time, first building up and then tearing down. This separates an unimplemented bit from a dropped bit and catches a clear that spills onto neighbouring bits. Each channel's error pulse is driven alone, which catches swapped channels or event fields. A pulse placed in the same cycle as a status read shows which of the two wins. A mix of live levels and latched flags shows whether a read clears only the latched bits.

// File: rtl/apr_pkg.sv
package apr_pkg;
    localparam int unsigned DATA_W = 32;
    localparam int unsigned ADDR_W = 8;

    localparam logic [ADDR_W-1:0] OFS_CMD   = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_MODEA = 8'h04;
    localparam logic [ADDR_W-1:0] OFS_MODEB = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_STAT  = 8'h0C;
    localparam logic [ADDR_W-1:0] OFS_A_EN  = 8'h10;
    localparam logic [ADDR_W-1:0] OFS_A_DIS = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_A_MSK = 8'h18;
    localparam logic [ADDR_W-1:0] OFS_A_STS = 8'h1C;
    localparam logic [ADDR_W-1:0] OFS_B_EN  = 8'h20;
    localparam logic [ADDR_W-1:0] OFS_B_DIS = 8'h24;
    localparam logic [ADDR_W-1:0] OFS_B_MSK = 8'h28;
    localparam logic [ADDR_W-1:0] OFS_B_STS = 8'h2C;
    localparam logic [ADDR_W-1:0] OFS_VER   = 8'hFC;

    // command bit positions
    localparam int unsigned CB_RX_ON  = 0;
    localparam int unsigned CB_RX_OFF = 1;
    localparam int unsigned CB_CK_ON  = 2;
    localparam int unsigned CB_CK_OFF = 3;
    localparam int unsigned CB_TX_ON  = 4;
    localparam int unsigned CB_TX_OFF = 5;
    localparam int unsigned CB_CLEAR  = 7;

    // status bit positions
    localparam int unsigned SB_RX = 0;
    localparam int unsigned SB_TX = 4;

    // group B layout
    localparam int unsigned GB_WERR  = 0;
    localparam int unsigned GB_TXRDY = 8;
    localparam int unsigned GB_TXEMP = 9;
    localparam int unsigned GB_RXRDY = 12;
    localparam int unsigned GB_RXFUL = 13;

    typedef struct packed {
        logic tx;
        logic ck;
        logic rx;
    } run_state_t;

    typedef struct packed {
        logic [DATA_W-1:0] mode_a;
        logic [DATA_W-1:0] mode_b;
    } mode_regs_t;
endpackage

// File: rtl/apr_cmd.sv
module apr_cmd
    import apr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_we,
    input  logic [DATA_W-1:0] cmd_wdata,
    output run_state_t        run_o
);
    run_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (cmd_we) begin
            if (cmd_wdata[CB_CLEAR]) begin
                st_d = '0;
            end else begin
                if (cmd_wdata[CB_RX_OFF])     st_d.rx = 1'b0;
                else if (cmd_wdata[CB_RX_ON]) st_d.rx = 1'b1;
                if (cmd_wdata[CB_CK_OFF])     st_d.ck = 1'b0;
                else if (cmd_wdata[CB_CK_ON]) st_d.ck = 1'b1;
                if (cmd_wdata[CB_TX_OFF])     st_d.tx = 1'b0;
                else if (cmd_wdata[CB_TX_ON]) st_d.tx = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign run_o = st_q;

    p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !cmd_we |=> $stable(st_q));
    p_off_wins_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[CB_RX_OFF] && cmd_wdata[CB_TX_OFF]) |=> (!st_q.rx && !st_q.tx));
    p_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_we && cmd_wdata[CB_CLEAR]) |=> (st_q == '0));
endmodule

// File: rtl/apr_irq_group.sv
module apr_irq_group #(
    parameter int unsigned W     = 32,
    parameter logic [W-1:0] IMPL  = '1,
    parameter logic [W-1:0] LATCH = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         en_we,
    input  logic         dis_we,
    input  logic [W-1:0] wdata,
    input  logic         rd_clr,
    input  logic         sw_rst,
    input  logic [W-1:0] ev_i,
    output logic [W-1:0] mask_o,
    output logic [W-1:0] status_o,
    output logic         pend_o
);
    localparam logic [W-1:0] LIVE = IMPL & ~LATCH;
    localparam logic [W-1:0] HELD = IMPL & LATCH;

    typedef struct packed {
        logic [W-1:0] mask;
        logic [W-1:0] flag;
    } grp_t;

    grp_t g_d, g_q;

    always_comb begin
        g_d = g_q;
        if (en_we)  g_d.mask = g_d.mask | (wdata & IMPL);
        if (dis_we) g_d.mask = g_d.mask & ~wdata;
        g_d.flag = ((g_q.flag & ~{W{rd_clr}}) | ev_i) & HELD;
        if (sw_rst) g_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    assign mask_o   = g_q.mask;
    assign status_o = (ev_i & LIVE) | g_q.flag;
    assign pend_o   = |(mask_o & status_o);

    p_mask_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_we && !dis_we && !sw_rst) |=> ((g_q.mask & $past(wdata & IMPL)) == $past(wdata & IMPL)));
    p_mask_clr_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (dis_we && !en_we) |=> ((g_q.mask & $past(wdata)) == '0));
    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_clr && !sw_rst) |=> ((g_q.flag & $past(g_q.flag)) == $past(g_q.flag)));
    p_pend_needs_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pend_o |-> (g_q.mask != '0));
endmodule

// File: rtl/audio_port_regs.sv
module audio_port_regs
    import apr_pkg::*;
#(
    parameter int unsigned NCH      = 8,
    parameter logic [11:0] REVISION = 12'h1A3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NCH-1:0]    tx_rdy_i,
    input  logic [NCH-1:0]    tx_unf_i,
    input  logic [NCH-1:0]    rx_rdy_i,
    input  logic [NCH-1:0]    rx_ovf_i,
    input  logic              wr_err_i,
    input  logic              txf_rdy_i,
    input  logic              txf_emp_i,
    input  logic              rxf_rdy_i,
    input  logic              rxf_ful_i,
    output logic              rx_on,
    output logic              clk_on,
    output logic              tx_on,
    output logic              irq
);
    localparam int unsigned FIELD = 8;
    localparam logic [DATA_W-1:0] CHM    = DATA_W'((64'd1 << NCH) - 64'd1);
    localparam logic [DATA_W-1:0] IMPL_A = CHM | (CHM << FIELD) | (CHM << (2*FIELD)) | (CHM << (3*FIELD));
    localparam logic [DATA_W-1:0] HELD_A = (CHM << FIELD) | (CHM << (3*FIELD));
    localparam logic [DATA_W-1:0] IMPL_B = (DATA_W'(1) << GB_WERR) | (DATA_W'(1) << GB_TXRDY)
                                         | (DATA_W'(1) << GB_TXEMP) | (DATA_W'(1) << GB_RXRDY)
                                         | (DATA_W'(1) << GB_RXFUL);
    localparam logic [DATA_W-1:0] HELD_B = (DATA_W'(1) << GB_WERR) | (DATA_W'(1) << GB_RXFUL);

    // address decode
    logic wr_cmd, wr_a_en, wr_a_dis, wr_b_en, wr_b_dis, clr_a, clr_b, sw_rst;
    assign wr_cmd   = bus_wr && (bus_addr == OFS_CMD);
    assign wr_a_en  = bus_wr && (bus_addr == OFS_A_EN);
    assign wr_a_dis = bus_wr && (bus_addr == OFS_A_DIS);
    assign wr_b_en  = bus_wr && (bus_addr == OFS_B_EN);
    assign wr_b_dis = bus_wr && (bus_addr == OFS_B_DIS);
    assign clr_a    = bus_rd && (bus_addr == OFS_A_STS);
    assign clr_b    = bus_rd && (bus_addr == OFS_B_STS);
    assign sw_rst   = wr_cmd && bus_wdata[CB_CLEAR];

    // command / run state
    run_state_t run;
    apr_cmd u_cmd (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_we    (wr_cmd),
        .cmd_wdata (bus_wdata),
        .run_o     (run)
    );
    assign rx_on  = run.rx;
    assign clk_on = run.ck;
    assign tx_on  = run.tx;

    // event vector assembly
    logic [DATA_W-1:0] ev_a, ev_b;
    for (genvar c = 0; c < FIELD; c++) begin : g_chan
        if (c < NCH) begin : g_used
            assign ev_a[c]           = tx_rdy_i[c];
            assign ev_a[FIELD+c]     = tx_unf_i[c];
            assign ev_a[2*FIELD+c]   = rx_rdy_i[c];
            assign ev_a[3*FIELD+c]   = rx_ovf_i[c];
        end else begin : g_tie
            assign ev_a[c]           = 1'b0;
            assign ev_a[FIELD+c]     = 1'b0;
            assign ev_a[2*FIELD+c]   = 1'b0;
            assign ev_a[3*FIELD+c]   = 1'b0;
        end
    end

    always_comb begin
        ev_b           = '0;
        ev_b[GB_WERR]  = wr_err_i;
        ev_b[GB_TXRDY] = txf_rdy_i;
        ev_b[GB_TXEMP] = txf_emp_i;
        ev_b[GB_RXRDY] = rxf_rdy_i;
        ev_b[GB_RXFUL] = rxf_ful_i;
    end

    // interrupt groups
    logic [DATA_W-1:0] mask_a, sts_a, mask_b, sts_b;
    logic pend_a, pend_b;

    apr_irq_group #(.W(DATA_W), .IMPL(IMPL_A), .LATCH(HELD_A)) u_grp_a (
        .clk (clk), .rst_n (rst_n),
        .en_we (wr_a_en), .dis_we (wr_a_dis), .wdata (bus_wdata),
        .rd_clr (clr_a), .sw_rst (sw_rst), .ev_i (ev_a),
        .mask_o (mask_a), .status_o (sts_a), .pend_o (pend_a)
    );

    apr_irq_group #(.W(DATA_W), .IMPL(IMPL_B), .LATCH(HELD_B)) u_grp_b (
        .clk (clk), .rst_n (rst_n),
        .en_we (wr_b_en), .dis_we (wr_b_dis), .wdata (bus_wdata),
        .rd_clr (clr_b), .sw_rst (sw_rst), .ev_i (ev_b),
        .mask_o (mask_b), .status_o (sts_b), .pend_o (pend_b)
    );

    assign irq = pend_a | pend_b;

    // mode words
    mode_regs_t mode_d, mode_q;

    always_comb begin
        mode_d = mode_q;
        if (bus_wr && (bus_addr == OFS_MODEA)) mode_d.mode_a = bus_wdata;
        if (bus_wr && (bus_addr == OFS_MODEB)) mode_d.mode_b = bus_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mode_q <= '0;
        else        mode_q <= mode_d;
    end

    // read mux
    always_comb begin
        bus_rdata = '0;
        unique case (bus_addr)
            OFS_MODEA: bus_rdata = mode_q.mode_a;
            OFS_MODEB: bus_rdata = mode_q.mode_b;
            OFS_STAT: begin
                bus_rdata[SB_RX] = run.rx;
                bus_rdata[SB_TX] = run.tx;
            end
            OFS_A_MSK: bus_rdata = mask_a;
            OFS_A_STS: bus_rdata = sts_a;
            OFS_B_MSK: bus_rdata = mask_b;
            OFS_B_STS: bus_rdata = sts_b;
            OFS_VER:   bus_rdata = {20'd0, REVISION};
            default:   bus_rdata = '0;
        endcase
    end

    p_irq_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
        ((mask_a == '0) && (mask_b == '0)) |-> !irq);
    p_mode_kept_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cmd |=> $stable(mode_q));
endmodule

// File: tb/sim_audio_port_regs.sv
`timescale 1ns/1ps
module sim_audio_port_regs;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_rdy_i = '0, tx_unf_i = '0, rx_rdy_i = '0, rx_ovf_i = '0;
    logic        wr_err_i = 0, txf_rdy_i = 0, txf_emp_i = 0, rxf_rdy_i = 0, rxf_ful_i = 0;
    logic        rx_on, clk_on, tx_on, irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit done    = 1'b0;

    always #10 clk = ~clk;

    audio_port_regs u0 (
        .clk, .rst_n, .bus_wr, .bus_rd, .bus_addr, .bus_wdata, .bus_rdata,
        .tx_rdy_i, .tx_unf_i, .rx_rdy_i, .rx_ovf_i,
        .wr_err_i, .txf_rdy_i, .txf_emp_i, .rxf_rdy_i, .rxf_ful_i,
        .rx_on, .clk_on, .tx_on, .irq
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #2 d = bus_rdata;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin : main
        logic [31:0] v;
        logic [31:0] acc;
        logic [2:0]  st;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // reset state
        rd(8'h0C, v); chk("R1 reset status", v, 32'h0);
        rd(8'h18, v); chk("R5 reset mask A", v, 32'h0);
        rd(8'h28, v); chk("R5 reset mask B", v, 32'h0);
        rd(8'h04, v); chk("R4 reset mode A", v, 32'h0);
        chk("R9 reset irq", {31'd0, irq}, 32'h0);
        chk("R1 reset run outputs", {29'd0, tx_on, clk_on, rx_on}, 32'h0);

        // revision and unmapped
        rd(8'hFC, v); chk("R10 revision", v, 32'h0000_01A3);
        rd(8'h40, v); chk("R10 unmapped", v, 32'h0);
        rd(8'h30, v); chk("R10 unmapped 30", v, 32'h0);

        // mode words and command read
        wr(8'h04, 32'hDEAD_BEEF); wr(8'h08, 32'h1234_5678);
        rd(8'h04, v); chk("R4 mode A", v, 32'hDEAD_BEEF);
        rd(8'h08, v); chk("R4 mode B", v, 32'h1234_5678);
        wr(8'h00, 32'h15);
        rd(8'h00, v); chk("R4 command reads zero", v, 32'h0);
        wr(8'h00, 32'h2A);

        // command sweep: 8 start states x 64 patterns
        for (int s = 0; s < 8; s++) begin
            for (int p = 0; p < 64; p++) begin
                logic [2:0] e;
                logic [31:0] pat;
                pat = 32'(p);
                wr(8'h00, {26'd0, s[2] ? 2'b01 : 2'b10, s[1] ? 2'b01 : 2'b10, s[0] ? 2'b01 : 2'b10});
                st = 3'(s);
                for (int f = 0; f < 3; f++) begin
                    if (pat[2*f+1])      e[f] = 1'b0;
                    else if (pat[2*f])   e[f] = 1'b1;
                    else                 e[f] = st[f];
                end
                wr(8'h00, pat);
                rd(8'h0C, v);
                chk((p[1] && p[0]) || (p[3] && p[2]) || (p[5] && p[4]) ? "R2 off wins" : "R1 command",
                    v, {27'd0, e[2], 3'd0, e[0]});
                chk("R1 clk_on", {31'd0, clk_on}, {31'd0, e[1]});
            end
        end
        wr(8'h00, 32'h2A);

        // mask sweep group A
        acc = '0;
        for (int b = 0; b < 32; b++) begin
            wr(8'h10, 32'd1 << b);
            acc |= (32'd1 << b);
            rd(8'h18, v); chk("R5 mask A set", v, acc);
        end
        for (int b = 0; b < 32; b++) begin
            wr(8'h14, 32'd1 << b);
            acc &= ~(32'd1 << b);
            rd(8'h18, v); chk("R5 mask A clear", v, acc);
        end
        // mask sweep group B
        acc = '0;
        for (int b = 0; b < 32; b++) begin
            wr(8'h20, 32'd1 << b);
            acc |= (32'd1 << b) & 32'h0000_3301;
            rd(8'h28, v); chk("R5 mask B set", v, acc);
        end
        wr(8'h24, 32'h0000_0100);
        rd(8'h28, v); chk("R5 mask B clear one", v, 32'h0000_3201);
        wr(8'h24, 32'hFFFF_FFFF);
        rd(8'h28, v); chk("R5 mask B clear all", v, 32'h0);

        // group A live levels
        tx_rdy_i = 8'hA5; rx_rdy_i = 8'h3C;
        rd(8'h1C, v); chk("R6 live levels", v, 32'h003C_00A5);
        tx_rdy_i = 8'h0F; rx_rdy_i = 8'hF0;
        rd(8'h1C, v); chk("R6 live follows", v, 32'h00F0_000F);
        tx_rdy_i = '0; rx_rdy_i = '0;

        // per-channel latched events
        for (int c = 0; c < 8; c++) begin
            @(negedge clk); tx_unf_i = 8'd1 << c; @(negedge clk); tx_unf_i = '0;
            idle();
            rd(8'h1C, v); chk("R6 underrun channel", v, 32'h0000_0100 << c);
            rd(8'h1C, v); chk("R8 underrun cleared", v, 32'h0);
            @(negedge clk); rx_ovf_i = 8'd1 << c; @(negedge clk); rx_ovf_i = '0;
            rd(8'h1C, v); chk("R6 overflow channel", v, 32'h0100_0000 << c);
            rd(8'h1C, v); chk("R8 overflow cleared", v, 32'h0);
        end

        // read clears latched but not live
        tx_rdy_i = 8'h01;
        @(negedge clk); rx_ovf_i = 8'h80; @(negedge clk); rx_ovf_i = '0;
        rd(8'h1C, v); chk("R8 mixed read", v, 32'h8000_0001);
        rd(8'h1C, v); chk("R8 live kept", v, 32'h0000_0001);
        tx_rdy_i = '0;

        // pulse coinciding with read
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = 8'h1C; tx_unf_i = 8'h04;
        @(negedge clk);
        bus_rd = 1'b0; tx_unf_i = '0;
        rd(8'h1C, v); chk("R8 pulse during read kept", v, 32'h0000_0400);
        rd(8'h1C, v); chk("R8 then cleared", v, 32'h0);

        // group B
        txf_rdy_i = 1; txf_emp_i = 1; rxf_rdy_i = 1;
        rd(8'h2C, v); chk("R7 live B", v, 32'h0000_1300);
        txf_rdy_i = 0; txf_emp_i = 0; rxf_rdy_i = 0;
        @(negedge clk); wr_err_i = 1; rxf_ful_i = 1; @(negedge clk); wr_err_i = 0; rxf_ful_i = 0;
        rd(8'h2C, v); chk("R7 latched B", v, 32'h0000_2001);
        rd(8'h2C, v); chk("R8 latched B cleared", v, 32'h0);

        // interrupt
        @(negedge clk); tx_unf_i = 8'h08; @(negedge clk); tx_unf_i = '0;
        chk("R9 flag without mask", {31'd0, irq}, 32'h0);
        wr(8'h10, 32'h0000_0800);
        chk("R9 masked flag raises", {31'd0, irq}, 32'h1);
        rd(8'h1C, v);
        chk("R9 read drops irq", {31'd0, irq}, 32'h0);
        wr(8'h14, 32'hFFFF_FFFF);
        wr(8'h20, 32'h0000_0200);
        txf_emp_i = 1; #2;
        chk("R9 live level irq", {31'd0, irq}, 32'h1);
        txf_emp_i = 0; #2;
        chk("R9 live level drops", {31'd0, irq}, 32'h0);
        wr(8'h24, 32'hFFFF_FFFF);

        // software reset
        wr(8'h04, 32'hCAFE_0001);
        wr(8'h00, 32'h15);
        wr(8'h10, 32'hFFFF_FFFF); wr(8'h20, 32'hFFFF_FFFF);
        @(negedge clk); rx_ovf_i = 8'h02; wr_err_i = 1; @(negedge clk); rx_ovf_i = '0; wr_err_i = 0;
        chk("R9 irq before clear", {31'd0, irq}, 32'h1);
        wr(8'h00, 32'h95);
        chk("R3 run cleared", {29'd0, tx_on, clk_on, rx_on}, 32'h0);
        chk("R3 irq cleared", {31'd0, irq}, 32'h0);
        rd(8'h18, v); chk("R3 mask A cleared", v, 32'h0);
        rd(8'h28, v); chk("R3 mask B cleared", v, 32'h0);
        rd(8'h1C, v); chk("R3 flags A cleared", v, 32'h0);
        rd(8'h2C, v); chk("R3 flags B cleared", v, 32'h0);
        rd(8'h04, v); chk("R3 mode A kept", v, 32'hCAFE_0001);
        rd(8'h08, v); chk("R3 mode B kept", v, 32'h1234_5678);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=%h expected=%h", 32'h0, 32'h1);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule